// File: doc/BRIEF.md
# Fan Tachometer Capture Timer

This block measures the time between fan tachometer pulses. A 16-bit counter starts at all ones. It counts down by one on every tick of an 8-bit programmable prescaler. When the synchronized tach input shows a rising edge, the block does three things: it latches the current count into a capture register, it raises a capture pending bit, and it reloads the counter to all ones so the next interval can be measured. Software turns the captured value into a speed. At two pulses per revolution, the elapsed ticks are all-ones minus the captured value.

A threshold register sets a timeout. If a decrement would bring the counter down to the threshold value before any pulse arrives, the block raises a timeout pending bit instead and reloads the counter. Typically the threshold is all ones minus the timeout length.

The block has a six-bit pending register, a write-one-to-clear register and an enable mask. A single interrupt output is high whenever an enabled pending bit is set. All registers are reached through a halfword bus with two byte lanes.

Top module: `tach_capture_timer`

## Requirements
- R1: After reset the registers hold these values: count 0xFFFF, capture 0xFFFF, threshold 0x0000, divider 0x00FF, run 0, pending 0, enable 0. The interrupt output is low.
- R2: Register map, selected by bus_addr[3:1] (bus_addr[0] is ignored):
  - 0: count (read/write)
  - 1: capture (read/write)
  - 2: threshold (read/write)
  - 3: divider, bits 7:0 (read/write)
  - 4: control, bit 0 = run (read/write)
  - 5: pending (read-only)
  - 6: clear (write-only, reads 0)
  - 7: enable, bits 5:0 (read/write)
- R3: While run is 1, the count decreases by one once every divider+1 clocks. The first decrement happens divider+1 clocks after the write that sets run. While run is 0, the count holds its value.
- R4: While running, a rising edge on tach_in is seen after a two-flop synchronizer. Two clocks after the input rises, the count value is latched into capture, pending bit 0 is set, and the count reloads to 0xFFFF. If tach_in rises k clocks after the run-setting write edge, the captured value is 0xFFFF - floor((k+2)/(divider+1)).
- R5: Falling edges on tach_in, and any edges that occur while run is 0, cause no capture and set no pending bit.
- R6: When a tick would decrement the count to a value equal to threshold, the following happens on that tick: pending bit 4 is set and the count reloads to 0xFFFF instead. If a capture occurs in the same cycle, the capture takes priority.
- R7: Writing the clear register with a 1 in bit n clears pending bit n. Bits written as 0 leave their pending bits unchanged. Pending bits 1, 2, 3 and 5 always read 0.
- R8: irq is high exactly when (pending & enable) is nonzero.
- R9: Writes update only the selected byte lanes: bus_be[0] selects bits 7:0 and bus_be[1] selects bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address; bits 3:1 select the register |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte-lane enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| tach_in | input | 1 | Asynchronous tach pulse input |
| irq | output | 1 | Interrupt, high while an enabled pending bit is set |

## Verification
The bench derives the expected captured value from the pulse arrival cycle and the divider, over many random dividers and arrival times.
- A synchronizer with the wrong depth, or a prescaler that divides by the divider rather than divider+1, shifts the captured value off the computed one.
- Timeout is checked on the exact cycle. An off-by-one compare, or a missing reload, shows up as an early, late or missing pending bit 4, or as a count that is not 0xFFFF afterward.
- Directed cases cover the following:
  - a falling edge while running
  - pulses while stopped
  - partial clears
  - single-lane writes
  - enable masks that hide a pending bit

Each of these catches a design that captures on the wrong events or disturbs neighbouring bits.

// File: rtl/tach_capture_timer.sv
module tach_capture_timer #(
  parameter int CNT_W   = 16,
  parameter int DIV_W   = 8,
  parameter int PEND_W  = 6,
  parameter int CAP_BIT = 0,
  parameter int TMO_BIT = 4,
  parameter int DIV_RST = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [1:0]       bus_be,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             tach_in,
  output logic             irq
);
  localparam logic [CNT_W-1:0] FULL = '1;
  localparam int LANES = CNT_W / 8;

  function automatic logic [CNT_W-1:0] lane_merge(input logic [CNT_W-1:0] old_v,
                                                  input logic [CNT_W-1:0] new_v,
                                                  input logic [1:0] be);
    logic [CNT_W-1:0] r;
    r = old_v;
    for (int i = 0; i < LANES; i++)
      if (be[i]) r[i*8 +: 8] = new_v[i*8 +: 8];
    return r;
  endfunction

  logic [1:0]        sync_q;
  logic              tach_prev_q;
  logic [CNT_W-1:0]  cnt_q, cap_q, thr_q;
  logic [DIV_W-1:0]  div_q, pre_q;
  logic              run_q;
  logic [PEND_W-1:0] pend_q, en_q;

  wire [2:0] sel    = bus_addr[3:1];
  wire cnt_wr       = bus_wr && sel == 3'd0;
  wire cap_wr       = bus_wr && sel == 3'd1;
  wire thr_wr       = bus_wr && sel == 3'd2;
  wire div_wr       = bus_wr && sel == 3'd3 && bus_be[0];
  wire ctl_wr       = bus_wr && sel == 3'd4 && bus_be[0];
  wire clr_wr       = bus_wr && sel == 3'd6 && bus_be[0];
  wire en_wr        = bus_wr && sel == 3'd7 && bus_be[0];

  wire              edge_ev = run_q && sync_q[1] && !tach_prev_q;
  wire              tick    = run_q && pre_q == div_q;
  wire [CNT_W-1:0]  cnt_dec = cnt_q - 1'b1;
  wire              tmo_ev  = tick && cnt_dec == thr_q && !edge_ev;

  wire [PEND_W-1:0] clr_mask = clr_wr ? bus_wdata[PEND_W-1:0] : '0;
  wire [PEND_W-1:0] set_mask = (PEND_W'(edge_ev) << CAP_BIT) | (PEND_W'(tmo_ev) << TMO_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q      <= '0;
      tach_prev_q <= 1'b0;
    end else begin
      sync_q      <= {sync_q[0], tach_in};
      tach_prev_q <= sync_q[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         pre_q <= '0;
    else if (!run_q || edge_ev || tick) pre_q <= '0;
    else                                pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= FULL;
    else if (edge_ev || tmo_ev) cnt_q <= FULL;
    else if (cnt_wr)            cnt_q <= lane_merge(cnt_q, bus_wdata, bus_be);
    else if (tick)              cnt_q <= cnt_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_q <= FULL;
    else if (edge_ev) cap_q <= cnt_q;
    else if (cap_wr)  cap_q <= lane_merge(cap_q, bus_wdata, bus_be);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= '0;
      div_q  <= DIV_W'(DIV_RST);
      run_q  <= 1'b0;
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (thr_wr) thr_q <= lane_merge(thr_q, bus_wdata, bus_be);
      if (div_wr) div_q <= bus_wdata[DIV_W-1:0];
      if (ctl_wr) run_q <= bus_wdata[0];
      if (en_wr)  en_q  <= bus_wdata[PEND_W-1:0];
      pend_q <= (pend_q & ~clr_mask) | set_mask;
    end
  end

  always_comb begin
    case (sel)
      3'd0:    bus_rdata = cnt_q;
      3'd1:    bus_rdata = cap_q;
      3'd2:    bus_rdata = thr_q;
      3'd3:    bus_rdata = CNT_W'(div_q);
      3'd4:    bus_rdata = CNT_W'(run_q);
      3'd5:    bus_rdata = CNT_W'(pend_q);
      3'd7:    bus_rdata = CNT_W'(en_q);
      default: bus_rdata = '0;
    endcase
  end

  assign irq = |(pend_q & en_q);
endmodule

// File: rtl/tach_capture_timer_chk.sv
module tach_capture_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int PEND_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              cnt_wr,
  input logic [CNT_W-1:0]  cnt,
  input logic [PEND_W-1:0] pend,
  input logic [PEND_W-1:0] en,
  input logic              irq
);
  assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  assert_reload_on_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[0]) |-> cnt == '1);

  assert_reload_on_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[4]) |-> cnt == '1);

  assert_unused_bits_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend[3:1] == 3'b000 && pend[5] == 1'b0);

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
endmodule

bind tach_capture_timer tach_capture_timer_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run_q), .cnt_wr(cnt_wr), .cnt(cnt_q),
  .pend(pend_q), .en(en_q), .irq(irq));

// File: tb/tach_capture_timer_tb.sv
module tach_capture_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CNT = 4'h0, A_CAP = 4'h2, A_THR = 4'h4, A_DIV = 4'h6,
                         A_CTL = 4'h8, A_PEND = 4'hA, A_CLR = 4'hC, A_EN = 4'hE;

  logic clk = 0, rst_n = 0, bus_wr = 0, tach_in = 0;
  logic [3:0]  bus_addr = 0;
  logic [1:0]  bus_be = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic irq;
  int compared = 0, mismatched = 0;

  tach_capture_timer dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tach_in(tach_in), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] exp_capture(input int k, input int d);
    return 16'hFFFF - 16'((k + 2) / (d + 1));
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; bus_be = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v, v2;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(A_CNT, v);  check("R1 count", v, 16'hFFFF);
    rd(A_CAP, v);  check("R1 capture", v, 16'hFFFF);
    rd(A_THR, v);  check("R1 threshold", v, 16'h0000);
    rd(A_DIV, v);  check("R1 divider", v, 16'h00FF);
    rd(A_CTL, v);  check("R1 run", v, 16'h0000);
    rd(A_PEND, v); check("R1 pending", v, 16'h0000);
    rd(A_EN, v);   check("R1 enable", v, 16'h0000);
    check("R1 irq", 16'(irq), 16'h0);

    // R9 / R2 byte lanes on threshold
    wr(A_THR, 16'hABCD, 2'b01); rd(A_THR, v); check("R9 low lane", v, 16'h00CD);
    wr(A_THR, 16'h12EF, 2'b10); rd(A_THR, v); check("R9 high lane", v, 16'h12CD);
    wr(A_THR, 16'h0000);

    // R3 prescaler rate then hold
    wr(A_DIV, 16'd3); wr(A_CTL, 16'd1);
    repeat (21) @(negedge clk);
    rd(A_CNT, v); check("R3 decrement rate", v, 16'hFFFF - 16'd5);
    wr(A_CTL, 16'd0);
    rd(A_CNT, v); repeat (12) @(negedge clk); rd(A_CNT, v2);
    check("R3 hold when stopped", v2, v);

    // R5 edges while stopped
    wr(A_CNT, 16'hFFFF);
    tach_in = 1; repeat (4) @(negedge clk); tach_in = 0; repeat (4) @(negedge clk);
    rd(A_PEND, v); check("R5 stopped edge no pending", v, 16'h0);
    rd(A_CAP, v);  check("R5 stopped edge no capture", v, 16'hFFFF);

    // R5 falling edge while running
    tach_in = 1; repeat (4) @(negedge clk);
    wr(A_CTL, 16'd1);
    repeat (3) @(negedge clk); tach_in = 0; repeat (5) @(negedge clk);
    wr(A_CTL, 16'd0);
    rd(A_PEND, v); check("R5 falling edge ignored", v, 16'h0);

    // R6 timeout exact cycle, D=2, T=5
    wr(A_CNT, 16'hFFFF); wr(A_DIV, 16'd2); wr(A_THR, 16'hFFFF - 16'd5);
    wr(A_CTL, 16'd1);
    bus_addr = A_PEND;
    repeat (14) @(negedge clk);
    rd(A_PEND, v); check("R6 no timeout early", v, 16'h0);
    @(negedge clk);
    rd(A_PEND, v); check("R6 timeout pending", v, 16'h0010);
    rd(A_CNT, v);  check("R6 reload after timeout", v, 16'hFFFF);
    wr(A_CTL, 16'd0); wr(A_THR, 16'h0000);

    // R4 directed capture with divider 0
    wr(A_CNT, 16'hFFFF); wr(A_DIV, 16'd0); wr(A_CTL, 16'd1);
    repeat (7) @(negedge clk); tach_in = 1; repeat (4) @(negedge clk);
    wr(A_CTL, 16'd0); tach_in = 0;
    rd(A_CAP, v); check("R4 capture divider 0", v, exp_capture(7, 0));
    rd(A_PEND, v); check("R4 capture pending", v, 16'h0011);

    // R8 masking
    wr(A_EN, 16'h0000); check("R8 masked", 16'(irq), 16'h0);
    wr(A_EN, 16'h0010); check("R8 timeout enabled", 16'(irq), 16'h1);
    // R7 partial clear
    wr(A_CLR, 16'h0010); rd(A_PEND, v); check("R7 clear bit4 only", v, 16'h0001);
    check("R8 only masked bit left", 16'(irq), 16'h0);
    wr(A_EN, 16'h0001); check("R8 capture enabled", 16'(irq), 16'h1);
    wr(A_CLR, 16'h0001); rd(A_PEND, v); check("R7 clear bit0", v, 16'h0000);
    rd(A_CLR, v); check("R2 clear reads zero", v, 16'h0000);
    repeat (3) @(negedge clk);

    // R4 random captures
    for (int it = 0; it < 40; it++) begin
      int d, k;
      logic [15:0] en;
      d  = $urandom % 6;
      k  = $urandom % 40;
      en = 16'($urandom % 2);
      wr(A_CLR, 16'h003F); wr(A_EN, en); wr(A_CNT, 16'hFFFF); wr(A_DIV, 16'(d));
      wr(A_CTL, 16'd1);
      repeat (k) @(negedge clk);
      tach_in = 1; repeat (4) @(negedge clk);
      wr(A_CTL, 16'd0); tach_in = 0;
      rd(A_CAP, v);  check("R4 random capture", v, exp_capture(k, d));
      rd(A_PEND, v); check("R4 random pending", v, 16'h0001);
      check("R8 random irq", 16'(irq), en);
      repeat (3) @(negedge clk);
    end
    finish_run();
  end
endmodule